// File: doc/BRIEF.md
# Multi-Rate Clock-Enable Strobe Bank

This block runs on one core clock and produces a vector of single-cycle enable strobes for downstream subsystems. Downstream logic uses them as clock enables instead of divided clocks. Three free-running rate generators run side by side. A fast one gives a 10 kHz update tick, a middle one gives a 100 ms tick and a slow one gives a 1 s timekeeping tick. Each period is derived at elaboration time from a core-frequency parameter.

Each subsystem output is wired to one of the three generators by a per-subsystem selector parameter. A power-management mask input carries one bit per subsystem. While a subsystem's bit is set, its enable stays low, so the logic behind it holds its state. The generators themselves never stop, so a subsystem that is unmasked again sees its strobes on the original schedule. The mask is registered on entry. No output of this block is ever meant to drive a clock pin.

Top module: `strobe_bank`

## Requirements
- R1: A generator of period P = CORE_HZ / rate (P clamped to at least 2) strobes on the P-th rising edge after reset is released and on every P-th edge after that, with no other strobes.
- R2: Every enable output is high for exactly one core-clock cycle per strobe and is never high on two consecutive cycles.
- R3: With default parameters (54 MHz core, rates 10000 Hz, 10 Hz and 1 Hz), the periods are 5400, 5,400,000 and 54,000,000 cycles, so subsystem 0 first strobes on the 5400th edge after reset.
- R4: A low level on the synchronous active-low reset clears all counters and the mask register at the next rising edge, and drives every enable low from that edge on.
- R5: While a subsystem's registered mask bit is 1, that subsystem's enable stays 0.
- R6: Masking does not stop the generators: after a mask bit clears, the next strobe lands on the same edge count (a multiple of P since reset) as it would have without masking.
- R7: The mask input is sampled on each rising edge. A strobe on edge k is suppressed exactly when the mask bit was 1 just before edge k.
- R8: Subsystem i takes its strobe from the generator chosen by SUBSYS_RATE bits [2i+1:2i]: 0 selects fast, 1 selects middle, 2 or 3 selects slow. The default maps subsystems 0..3 to fast, middle, slow and fast.
- R9: Unmasked subsystems that select the same generator strobe on the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; every output is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_mask_i | input | NUM_SUBSYS | Power-management mask, one bit per subsystem; 1 suppresses that enable |
| ce_o | output | NUM_SUBSYS | Gated single-cycle enable strobes, one per subsystem |

## Verification
The main schedule is run unmasked long enough to see all three scaled generators fire. A second instance at default parameters confirms the real fast period, which separates a correct period from an off-by-one terminal count. A mask window that spans several fast strobes shows that suppression is total and that the phase is kept afterwards. Mask edges placed one cycle before a middle-rate strobe separate a registered mask from an unregistered or late one. A reset in the middle of the run shows that every counter restarts from zero rather than resuming.

// File: rtl/strobe_bank_pkg.sv
// Shared constants and elaboration-time helpers for the strobe bank.
// Assumes rates are given in Hz and the core frequency is at least twice
// the fastest rate; smaller periods are clamped to 2 cycles.
package strobe_bank_pkg;

    localparam int NUM_RATES = 3;

    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_MID  = 2'd1,
        RATE_SLOW = 2'd2
    } rate_sel_e;

    // Number of core cycles between strobes for one rate generator.
    function automatic int unsigned period_cycles(int unsigned core_hz,
                                                  int unsigned rate_hz);
        int unsigned p;
        p = (rate_hz == 0) ? 2 : core_hz / rate_hz;
        return (p < 2) ? 2 : p;
    endfunction

    // Counter width able to hold period-1.
    function automatic int unsigned cnt_width(int unsigned period);
        return (period > 2) ? $clog2(period) : 1;
    endfunction

    // Generator index selected by a two-bit selector field (3 folds onto slow).
    function automatic int unsigned rate_index(logic [1:0] sel);
        return (sel >= 2'(RATE_SLOW)) ? 2 : int'(sel);
    endfunction

endpackage

// File: rtl/strobe_rate_counter.sv
// One free-running rate generator. It counts core cycles 0..PERIOD-1 and
// raises a registered tick for the single cycle that follows the terminal
// count. Assumes PERIOD >= 2, so the tick is never high twice in a row.
module strobe_rate_counter #(
    parameter int unsigned PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int unsigned    CW   = strobe_bank_pkg::cnt_width(PERIOD);
    localparam logic [CW-1:0]  LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Advance the counter, wrap at the terminal value and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/strobe_mask_reg.sv
// Entry register for the power-management mask. It decouples the mask
// source from the gating logic; a change applies from the next edge on.
module strobe_mask_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] mask_q
);

    // Capture the mask each edge; reset leaves every subsystem unmasked.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_i;
    end

endmodule

// File: rtl/strobe_router.sv
// Connects each subsystem to its chosen rate generator and gates the
// strobe with the registered mask bit. Purely combinational, and fed only
// by registers, so each output is a clean one-cycle pulse.
module strobe_router #(
    parameter int                    NUM_SUBSYS  = 4,
    parameter logic [2*NUM_SUBSYS-1:0] SUBSYS_RATE = '0
) (
    input  logic [strobe_bank_pkg::NUM_RATES-1:0] tick_i,
    input  logic [NUM_SUBSYS-1:0]                 mask_i,
    output logic [NUM_SUBSYS-1:0]                 ce_o
);

    for (genvar i = 0; i < NUM_SUBSYS; i++) begin : g_sub
        localparam int unsigned SRC =
            strobe_bank_pkg::rate_index(SUBSYS_RATE[2*i +: 2]);
        // Gate the selected tick with this subsystem's mask bit.
        assign ce_o[i] = tick_i[SRC] & ~mask_i[i];
    end

endmodule

// File: rtl/strobe_bank.sv
// Multi-rate clock-enable strobe bank. Three rate generators share the
// core clock; a router hands one to each subsystem, gated by a registered
// power-management mask. Assumes every output is used as an enable only.
module strobe_bank #(
    parameter int unsigned             CORE_HZ     = 54_000_000,
    parameter int unsigned             FAST_HZ     = 10_000,
    parameter int unsigned             MID_HZ      = 10,
    parameter int unsigned             SLOW_HZ     = 1,
    parameter int                      NUM_SUBSYS  = 4,
    parameter logic [2*NUM_SUBSYS-1:0] SUBSYS_RATE = 8'b00_10_01_00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SUBSYS-1:0] pm_mask_i,
    output logic [NUM_SUBSYS-1:0] ce_o
);

    import strobe_bank_pkg::*;

    logic [NUM_RATES-1:0]  rate_tick;
    logic [NUM_SUBSYS-1:0] mask_q;

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        localparam int unsigned HZ =
            (r == 0) ? FAST_HZ : (r == 1) ? MID_HZ : SLOW_HZ;
        strobe_rate_counter #(
            .PERIOD (period_cycles(CORE_HZ, HZ))
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_o (rate_tick[r])
        );
    end

    strobe_mask_reg #(
        .W (NUM_SUBSYS)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (pm_mask_i),
        .mask_q (mask_q)
    );

    strobe_router #(
        .NUM_SUBSYS  (NUM_SUBSYS),
        .SUBSYS_RATE (SUBSYS_RATE)
    ) u_route (
        .tick_i (rate_tick),
        .mask_i (mask_q),
        .ce_o   (ce_o)
    );

endmodule

// File: rtl/strobe_bank_chk.sv
// Property checker for strobe_bank, attached by bind. It keeps its own
// cycle counters per rate to judge the tick schedule over long periods.
module strobe_bank_chk #(
    parameter int unsigned             CORE_HZ     = 54_000_000,
    parameter int unsigned             FAST_HZ     = 10_000,
    parameter int unsigned             MID_HZ      = 10,
    parameter int unsigned             SLOW_HZ     = 1,
    parameter int                      NUM_SUBSYS  = 4,
    parameter logic [2*NUM_SUBSYS-1:0] SUBSYS_RATE = 8'b00_10_01_00
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [NUM_SUBSYS-1:0]                 pm_mask_i,
    input logic [NUM_SUBSYS-1:0]                 ce_o,
    input logic [strobe_bank_pkg::NUM_RATES-1:0] rate_tick
);

    import strobe_bank_pkg::*;

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        localparam int unsigned HZ =
            (r == 0) ? FAST_HZ : (r == 1) ? MID_HZ : SLOW_HZ;
        localparam int unsigned PER = period_cycles(CORE_HZ, HZ);
        int unsigned seen_q;

        // Independent count of edges since reset, modulo the period.
        always_ff @(posedge clk) begin
            if (!rst_n)                seen_q <= 0;
            else if (seen_q == PER - 1) seen_q <= 0;
            else                       seen_q <= seen_q + 1;
        end

        assert_tick_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q == PER - 1) |=> rate_tick[r]);
        assert_tick_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q != PER - 1) |=> !rate_tick[r]);
    end

    for (genvar i = 0; i < NUM_SUBSYS; i++) begin : g_sub
        localparam int unsigned SRC = rate_index(SUBSYS_RATE[2*i +: 2]);

        assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ce_o[i] |=> !ce_o[i]);
        assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pm_mask_i[i] |=> !ce_o[i]);
        assert_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ce_o[i] |-> rate_tick[SRC]);

        for (genvar j = i + 1; j < NUM_SUBSYS; j++) begin : g_pair
            if (rate_index(SUBSYS_RATE[2*j +: 2]) == SRC) begin : g_same
                assert_shared_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pm_mask_i[i] && !pm_mask_i[j]) |=> (ce_o[i] == ce_o[j]));
            end
        end
    end

    // R4: a reset edge leaves every enable low.
    assert_reset_clears_R4: assert property (@(posedge clk)
        !rst_n |=> (ce_o == '0));

endmodule

bind strobe_bank strobe_bank_chk #(
    .CORE_HZ     (CORE_HZ),
    .FAST_HZ     (FAST_HZ),
    .MID_HZ      (MID_HZ),
    .SLOW_HZ     (SLOW_HZ),
    .NUM_SUBSYS  (NUM_SUBSYS),
    .SUBSYS_RATE (SUBSYS_RATE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pm_mask_i (pm_mask_i),
    .ce_o      (ce_o),
    .rate_tick (rate_tick)
);

// File: tb/sim_strobe_bank.sv
`timescale 1ns/1ps
// Bench: a behavioural edge-count model is compared with the outputs on
// every clock; directed checks cover masking, reset and default periods.
module sim_strobe_bank;

    localparam int CORE = 20000;
    localparam int P_F  = 8;       // 20000 / 2500
    localparam int P_M  = 2000;    // 20000 / 10
    localparam int P_S  = 20000;   // 20000 / 1
    localparam int DEF_PF = 5400;  // default fast period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst1_n = 1'b0;
    logic [3:0] mask = '0;
    logic [3:0] ce;
    logic [3:0] ce1;

    always #2 clk = ~clk;

    strobe_bank #(
        .CORE_HZ (CORE), .FAST_HZ (2500), .MID_HZ (10), .SLOW_HZ (1)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .pm_mask_i (mask), .ce_o (ce)
    );

    strobe_bank u1 (
        .clk (clk), .rst_n (rst1_n), .pm_mask_i (4'b0000), .ce_o (ce1)
    );

    int vectors = 0;
    int miscompares = 0;
    int k = 0;
    int k1 = 0;
    logic [3:0] mask_m = '0;
    logic [3:0] prev_ce = '0;
    int hi_cnt [4] = '{0, 0, 0, 0};
    int masked_hits = 0;
    int masked_slots = 0;
    int last_k0 = 0;
    int first_u1 = -1;

    function automatic int period_of(int i);
        case (i)
            1:       return P_M;
            2:       return P_S;
            default: return P_F;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference model state: edges since reset and the sampled mask.
    always @(posedge clk) begin
        k      <= rst_n ? k + 1 : 0;
        mask_m <= rst_n ? mask : 4'b0000;
        k1     <= rst1_n ? k1 + 1 : 0;
    end

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        logic [3:0] want;
        logic [3:0] want1;
        for (int i = 0; i < 4; i++)
            want[i] = (k > 0) && (k % period_of(i) == 0) && !mask_m[i];
        check(ce === want, "R1", "u0 strobe schedule", ce, want);
        want1 = {(k1 > 0) && (k1 % DEF_PF == 0), 2'b00,
                 (k1 > 0) && (k1 % DEF_PF == 0)};
        check(ce1 === want1, "R3", "default-parameter schedule", ce1, want1);
        for (int i = 0; i < 4; i++) begin
            if (prev_ce[i]) check(!ce[i], "R2", "enable high two cycles", ce[i], 0);
            if (ce[i]) hi_cnt[i]++;
        end
        if (!mask_m[0] && !mask_m[3])
            check(ce[0] == ce[3], "R9", "shared fast rate mismatch", ce[3], ce[0]);
        if (mask_m[0] && k > 0 && k % P_F == 0) masked_slots++;
        if (mask_m[0] && ce[0]) masked_hits++;
        if (ce[0]) last_k0 = k;
        if (ce1[0] && first_u1 < 0) first_u1 = k1;
        prev_ce = ce;
    end

    task automatic wait_k(int target);
        while (k != target) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ce == 4'b0000 && ce1 == 4'b0000, "R4", "enables during reset", ce, 0);
        rst_n  = 1'b1;
        rst1_n = 1'b1;

        // Unmasked run past the first slow strobe.
        wait_k(20005);
        check(hi_cnt[2] == 1, "R8", "slow subsystem strobe count", hi_cnt[2], 1);
        check(hi_cnt[1] == 10, "R8", "middle subsystem strobe count", hi_cnt[1], 10);
        check(hi_cnt[0] == 2500, "R1", "fast subsystem strobe count", hi_cnt[0], 2500);

        // Mask subsystem 0 across several fast strobes.
        mask[0] = 1'b1;
        wait_k(20050);
        mask[0] = 1'b0;
        wait_k(20060);
        check(masked_hits == 0, "R5", "strobes leaked while masked", masked_hits, 0);
        check(masked_slots >= 5, "R5", "masked strobe slots seen", masked_slots, 5);
        check(last_k0 == 20056, "R6", "first strobe after unmask", last_k0, 20056);

        // Mask edge one cycle ahead of a middle-rate strobe.
        wait_k(21999);
        mask[1] = 1'b1;
        @(negedge clk);
        check(ce[1] == 1'b0, "R7", "strobe at 22000 suppressed", ce[1], 0);
        wait_k(23999);
        mask[1] = 1'b0;
        @(negedge clk);
        check(ce[1] == 1'b1, "R7", "strobe at 24000 after unmask", ce[1], 1);

        // Reset in mid-run restarts every counter.
        wait_k(24103);
        rst_n = 1'b0;
        @(negedge clk);
        check(ce == 4'b0000, "R4", "enables after mid-run reset", ce, 0);
        check(k == 0, "R4", "edge count restarted", k, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_k(20002);
        check(hi_cnt[2] == 2, "R1", "slow strobe after restart", hi_cnt[2], 2);
        check(first_u1 == DEF_PF, "R3", "default fast first strobe edge", first_u1, DEF_PF);

        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", k, 0);
        summary();
        $finish;
    end

endmodule